// File: doc/BRIEF.md
# GPIO Controller with Latched Edge Causes

This block is a register-mapped general-purpose I/O controller for up to 32 pins. A 32-bit register bus reaches it, and a 2-bit region select chooses one of four windows. The main window holds the edge-detect enables and the live input levels. The cause window holds the event mask, the masked pending view and the acknowledge port. The set window and the clear window change the output-enable and output-data bits one bit at a time. Software never has to read, modify and write these bits.

Each pin input passes through a two-flop synchronizer. A rising or falling transition on the synchronized level sets a sticky cause bit for that pin, provided the matching edge enable is on. The cause bit stays set until software writes a one to it through the acknowledge port. The cause bits are ANDed with the event mask and OR-reduced into one interrupt line. An instance with fewer than 32 pins reads zero on every bit above its pin count.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register, every cause bit, `pin_oe`, `pin_out`, `irq` and `rdata` are zero.
- R2: A write to region 2 (set window) with offset 0x00 ORs `wdata` into output enable. With offset 0x04 it ORs `wdata` into output data. Bits written as 0 are unchanged.
- R3: A write to region 3 (clear window) with offset 0x00 clears the output-enable bits where `wdata` is 1. With offset 0x04 it clears the output-data bits in the same way. Bits written as 0 are unchanged.
- R4: In region 0 (main), offset 0x00 is the rising-edge enable and offset 0x04 is the falling-edge enable. Both are read-write. In regions 2 and 3, offsets 0x00 and 0x04 read back output enable and output data.
- R5: A read of region 0 at offset 0x08 returns the pin levels after two synchronizer flops.
- R6: A synchronized 0-to-1 transition sets the pin's cause bit when its rising enable is on. A 1-to-0 transition sets it when its falling enable is on. With both enables on, either edge sets it. With neither on, the cause bit is not set.
- R7: In region 1 (cause), offset 0x14 is the read-write event mask. Offset 0x00 reads the cause bits ANDed with the mask.
- R8: A write to region 1 at offset 0x18 clears each cause bit where `wdata` is 1. Cause bits written as 0 are unaffected.
- R9: `irq` is high exactly when some cause bit is set and its mask bit is on. It stays high until every masked cause bit is cleared or unmasked.
- R10: When an edge is detected in the same cycle that an acknowledge write clears the same bit, the cause bit remains set.
- R11: With NUM_PINS below 32, register bits at and above NUM_PINS read as zero.
- R12: Read data appears on `rdata` in the cycle after `rd_en`. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Region select: 0 main, 1 cause, 2 set, 3 clear |
| addr | input | 5 | Byte offset within the region |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Pin input levels |
| pin_oe | output | NUM_PINS | Output-enable per pin |
| pin_out | output | NUM_PINS | Output data per pin |
| irq | output | 1 | Masked, OR-reduced interrupt |

## Verification
Register writes take effect at the next clock edge, so `pin_oe`, `pin_out` and mask changes are checked one cycle after the strobe. Read data is checked one cycle after `rd_en`. A pin change reaches the level register two edges later, and it reaches the cause bit and `irq` on the third edge. The bench therefore drives on falling edges and waits three full cycles after each pin change before it compares anything. The R10 collision case is timed so that the acknowledge write lands on the same edge that latches the edge.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    RGN_MAIN  = 2'd0,
    RGN_CAUSE = 2'd1,
    RGN_SET   = 2'd2,
    RGN_CLR   = 2'd3
  } region_e;

  // main region
  localparam logic [ADDR_W-1:0] OFS_RISE  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_FALL  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_LEVEL = 5'h08;
  // set / clear regions
  localparam logic [ADDR_W-1:0] OFS_OE    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DOUT  = 5'h04;
  // cause region
  localparam logic [ADDR_W-1:0] OFS_PEND  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 5'h18;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] rise_en,
  input  logic [NUM_PINS-1:0] fall_en,
  output logic [NUM_PINS-1:0] level,
  output logic [NUM_PINS-1:0] edge_hit
);
  logic [NUM_PINS-1:0] meta_q, lvl_q, prev_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        lvl_q[i]  <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= pin_in[i];
        lvl_q[i]  <= meta_q[i];
        prev_q[i] <= lvl_q[i];
      end
    end

    always_comb begin
      edge_hit[i] = (rise_en[i] &  lvl_q[i] & ~prev_q[i]) |
                    (fall_en[i] & ~lvl_q[i] &  prev_q[i]);
    end
  end

  assign level = lvl_q;
endmodule

// File: rtl/gpio_cause_bank.sv
`timescale 1ns/1ps
module gpio_cause_bank #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] edge_hit,
  input  logic [NUM_PINS-1:0] ack_mask,
  output logic [NUM_PINS-1:0] cause_q
);
  logic [NUM_PINS-1:0] cause_n;
  logic                cause_ce;

  // a new edge wins over an acknowledge of the same bit
  always_comb begin
    cause_ce = (|edge_hit) | (|ack_mask);
    cause_n  = (cause_q & ~ack_mask) | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_ce) cause_q <= cause_n;
  end
endmodule

// File: rtl/gpio_ctrl_regs.sv
`timescale 1ns/1ps
module gpio_ctrl_regs
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  region_e             sel,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wd,
  output logic [NUM_PINS-1:0] oe_q,
  output logic [NUM_PINS-1:0] dout_q,
  output logic [NUM_PINS-1:0] rise_q,
  output logic [NUM_PINS-1:0] fall_q,
  output logic [NUM_PINS-1:0] mask_q,
  output logic [NUM_PINS-1:0] ack_mask
);
  logic [NUM_PINS-1:0] oe_n, dout_n, rise_n, fall_n, mask_n;

  always_comb begin
    oe_n     = oe_q;
    dout_n   = dout_q;
    rise_n   = rise_q;
    fall_n   = fall_q;
    mask_n   = mask_q;
    ack_mask = '0;
    if (wr_en) begin
      unique case (sel)
        RGN_SET: begin
          if (addr == OFS_OE)   oe_n   = oe_q | wd;
          if (addr == OFS_DOUT) dout_n = dout_q | wd;
        end
        RGN_CLR: begin
          if (addr == OFS_OE)   oe_n   = oe_q & ~wd;
          if (addr == OFS_DOUT) dout_n = dout_q & ~wd;
        end
        RGN_MAIN: begin
          if (addr == OFS_RISE) rise_n = wd;
          if (addr == OFS_FALL) fall_n = wd;
        end
        RGN_CAUSE: begin
          if (addr == OFS_MASK) mask_n   = wd;
          if (addr == OFS_ACK)  ack_mask = wd;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= '0;
      dout_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      oe_q   <= oe_n;
      dout_q <= dout_n;
      rise_q <= rise_n;
      fall_q <= fall_n;
      mask_q <= mask_n;
    end
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
`timescale 1ns/1ps
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          sel,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [BUS_W-1:0]    wdata,
  output logic [BUS_W-1:0]    rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic                irq
);
  logic [1:0]          rst_pipe;
  logic                rst_int_n;
  region_e             rgn;
  logic [NUM_PINS-1:0] oe_q, dout_q, rise_q, fall_q, mask_q, ack_mask;
  logic [NUM_PINS-1:0] level, edge_hit, cause_q, pend;
  logic [NUM_PINS-1:0] rd_sel;
  logic                rd_hit;
  logic [BUS_W-1:0]    rd_ext;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];
  assign rgn       = region_e'(sel);

  gpio_ctrl_regs #(.NUM_PINS(NUM_PINS)) regs_i (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .sel(rgn), .addr(addr),
    .wd(wdata[NUM_PINS-1:0]), .oe_q(oe_q), .dout_q(dout_q), .rise_q(rise_q),
    .fall_q(fall_q), .mask_q(mask_q), .ack_mask(ack_mask)
  );

  gpio_in_sync #(.NUM_PINS(NUM_PINS)) sync_i (
    .clk(clk), .rst_n(rst_int_n), .pin_in(pin_in), .rise_en(rise_q),
    .fall_en(fall_q), .level(level), .edge_hit(edge_hit)
  );

  gpio_cause_bank #(.NUM_PINS(NUM_PINS)) cause_i (
    .clk(clk), .rst_n(rst_int_n), .edge_hit(edge_hit), .ack_mask(ack_mask),
    .cause_q(cause_q)
  );

  assign pend    = cause_q & mask_q;
  assign irq     = |pend;
  assign pin_oe  = oe_q;
  assign pin_out = dout_q;

  always_comb begin
    rd_sel = '0;
    rd_hit = 1'b1;
    unique case (rgn)
      RGN_MAIN: begin
        if      (addr == OFS_RISE)  rd_sel = rise_q;
        else if (addr == OFS_FALL)  rd_sel = fall_q;
        else if (addr == OFS_LEVEL) rd_sel = level;
        else                        rd_hit = 1'b0;
      end
      RGN_CAUSE: begin
        if      (addr == OFS_PEND)  rd_sel = pend;
        else if (addr == OFS_MASK)  rd_sel = mask_q;
        else                        rd_hit = 1'b0;
      end
      default: begin
        if      (addr == OFS_OE)    rd_sel = oe_q;
        else if (addr == OFS_DOUT)  rd_sel = dout_q;
        else                        rd_hit = 1'b0;
      end
    endcase
    rd_ext = '0;
    if (rd_hit) rd_ext[NUM_PINS-1:0] = rd_sel;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata <= '0;
    else if (rd_en)  rdata <= rd_ext;
  end
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_chk
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_int_n,
  input logic [1:0]          sel,
  input logic [ADDR_W-1:0]   addr,
  input logic                wr_en,
  input logic [BUS_W-1:0]    wdata,
  input logic [BUS_W-1:0]    rdata,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq,
  input logic [NUM_PINS-1:0] edge_hit,
  input logic [NUM_PINS-1:0] cause_q
);
  logic set_oe_wr, clr_oe_wr, irq_touch;
  assign set_oe_wr = wr_en && sel == 2'd2 && addr == OFS_OE;
  assign clr_oe_wr = wr_en && sel == 2'd3 && addr == OFS_OE;
  assign irq_touch = wr_en && sel == 2'd1 && (addr == OFS_MASK || addr == OFS_ACK);

  a_r2_set_oe: assert property (@(posedge clk) disable iff (!rst_int_n)
    set_oe_wr |=> ((pin_oe & $past(wdata[NUM_PINS-1:0])) == $past(wdata[NUM_PINS-1:0])));

  a_r3_clr_oe: assert property (@(posedge clk) disable iff (!rst_int_n)
    clr_oe_wr |=> ((pin_oe & $past(wdata[NUM_PINS-1:0])) == '0));

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq && !irq_touch) |=> irq);

  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|edge_hit) |=> ((cause_q & $past(edge_hit)) == $past(edge_hit)));

  a_r1_no_spurious_cause: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!(|edge_hit)) |=> ((cause_q & ~$past(cause_q)) == '0));

  if (NUM_PINS < BUS_W) begin : g_narrow
    a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
      rdata[BUS_W-1:NUM_PINS] == '0);
  end
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk(clk), .rst_int_n(rst_int_n), .sel(sel), .addr(addr), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .pin_oe(pin_oe), .irq(irq),
  .edge_hit(edge_hit), .cause_q(cause_q)
);

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = '0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata24;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_oe, pin_out;
  logic [23:0] pin_oe24, pin_out24;
  logic        irq, irq24;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [31:0] m_oe = 0, m_out = 0, m_rise = 0, m_fall = 0, m_mask = 0, m_cause = 0, m_pins = 0;

  always #2.5 clk = ~clk;

  gpio_edge_ctrl #(.NUM_PINS(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .irq(irq));

  gpio_edge_ctrl #(.NUM_PINS(24)) dut24_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata24), .pin_in(pin_in[23:0]), .pin_oe(pin_oe24),
    .pin_out(pin_out24), .irq(irq24));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [1:0] s, input logic [4:0] a);
    case (s)
      2'd0: return a == 5'h00 ? m_rise : a == 5'h04 ? m_fall : a == 5'h08 ? m_pins : 32'h0;
      2'd1: return a == 5'h00 ? (m_cause & m_mask) : a == 5'h14 ? m_mask : 32'h0;
      default: return a == 5'h00 ? m_oe : a == 5'h04 ? m_out : 32'h0;
    endcase
  endfunction

  function automatic void model_wr(input logic [1:0] s, input logic [4:0] a, input logic [31:0] d);
    case (s)
      2'd0: begin if (a == 5'h00) m_rise = d; if (a == 5'h04) m_fall = d; end
      2'd1: begin if (a == 5'h14) m_mask = d; if (a == 5'h18) m_cause = m_cause & ~d; end
      2'd2: begin if (a == 5'h00) m_oe = m_oe | d; if (a == 5'h04) m_out = m_out | d; end
      default: begin if (a == 5'h00) m_oe = m_oe & ~d; if (a == 5'h04) m_out = m_out & ~d; end
    endcase
  endfunction

  task automatic bus_wr(input logic [1:0] s, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = s; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(s, a, d);
  endtask

  task automatic bus_rd(input string req, input logic [1:0] s, input logic [4:0] a);
    @(negedge clk);
    sel = s; addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rdata, exp_read(s, a));
  endtask

  // pin change: level after 2 edges, cause/irq after 3
  task automatic drive_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    m_cause = m_cause | (v & ~m_pins & m_rise) | (~v & m_pins & m_fall);
    m_pins = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " R2/R3 pin_oe"}, pin_oe, m_oe);
    chk({tag, " R2/R3 pin_out"}, pin_out, m_out);
    chk({tag, " R9 irq"}, {31'b0, irq}, {31'b0, |(m_cause & m_mask)});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [4:0] ofs [5];
    ofs[0] = 5'h00; ofs[1] = 5'h04; ofs[2] = 5'h08; ofs[3] = 5'h14; ofs[4] = 5'h18;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pin_oe", pin_oe, 0);
    bus_rd("R1 cause", 2'd1, 5'h00);
    bus_rd("R1 rise", 2'd0, 5'h00);

    // R2 / R3 directed
    bus_wr(2'd2, 5'h00, 32'h0000_00F0); chk_outs("r2_set_oe");
    bus_wr(2'd2, 5'h00, 32'h0000_000F); chk("R2 oe keep", pin_oe, 32'h0000_00FF);
    bus_wr(2'd2, 5'h04, 32'hA5A5_0000); chk("R2 dout", pin_out, 32'hA5A5_0000);
    bus_wr(2'd3, 5'h00, 32'h0000_0011); chk("R3 oe clr", pin_oe, 32'h0000_00EE);
    bus_wr(2'd3, 5'h04, 32'h8000_0000); chk("R3 dout clr", pin_out, 32'h25A5_0000);
    bus_rd("R4 readback oe", 2'd2, 5'h00);
    bus_rd("R4 readback dout", 2'd3, 5'h04);

    // R4 / R12
    bus_wr(2'd0, 5'h00, 32'h0000_0003);
    bus_wr(2'd0, 5'h04, 32'h0000_0006);
    bus_rd("R4 rise", 2'd0, 5'h00);
    bus_rd("R4 fall", 2'd0, 5'h04);
    bus_rd("R12 unmapped", 2'd0, 5'h0C);
    bus_rd("R12 unmapped cause ack", 2'd1, 5'h18);

    // R6 / R7 / R9 directed: pin0 rise only, pin1 both, pin2 fall only, pin3 none
    bus_wr(2'd1, 5'h14, 32'h0000_000F);
    drive_pins(32'h0000_000F);
    bus_rd("R5 level", 2'd0, 5'h08);
    bus_rd("R6 rise cause", 2'd1, 5'h00);
    chk_outs("r9_rise");
    drive_pins(32'h0000_0000);
    bus_rd("R6 fall cause", 2'd1, 5'h00);
    bus_wr(2'd1, 5'h14, 32'h0000_0004);
    bus_rd("R7 mask view", 2'd1, 5'h00);
    chk_outs("r7_mask");
    bus_wr(2'd1, 5'h18, 32'h0000_0001);
    chk_outs("r8_other_bit");
    bus_wr(2'd1, 5'h18, 32'h0000_0004);
    chk_outs("r8_clear");
    bus_wr(2'd1, 5'h14, 32'h0000_0003);
    bus_rd("R8 unacked stay", 2'd1, 5'h00);
    bus_wr(2'd1, 5'h18, 32'hFFFF_FFFF);
    chk_outs("r9_drop");

    // R10 edge coincident with acknowledge of same bit
    bus_wr(2'd0, 5'h00, 32'h0000_0001);
    drive_pins(32'h0000_0001);
    drive_pins(32'h0000_0000);
    drive_pins(32'h0000_0001);
    bus_wr(2'd0, 5'h04, 32'h0000_0001);
    @(negedge clk);
    pin_in = 32'h0;
    @(negedge clk);
    @(negedge clk);
    sel = 2'd1; addr = 5'h18; wdata = 32'h1; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    m_pins = 32'h0; m_cause = 32'h1;
    bus_rd("R10 edge wins", 2'd1, 5'h00);
    chk_outs("r10_irq");
    bus_wr(2'd1, 5'h18, 32'hFFFF_FFFF);

    // R11 narrow instance
    bus_wr(2'd0, 5'h00, 32'hFFFF_FFFF);
    @(negedge clk); sel = 2'd0; addr = 5'h00; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R11 narrow rise", rdata24, 32'h00FF_FFFF);
    bus_wr(2'd2, 5'h00, 32'hFFFF_FFFF);
    @(negedge clk); sel = 2'd2; addr = 5'h00; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R11 narrow oe", rdata24, 32'h00FF_FFFF);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [1:0]  s;
      logic [4:0]  a;
      logic [31:0] d;
      op = $urandom_range(0, 3);
      s  = 2'($urandom_range(0, 3));
      a  = ofs[$urandom_range(0, 4)];
      d  = $urandom();
      case (op)
        0: begin bus_wr(s, a, d); chk_outs("r2_r3_r8_rand"); end
        1: bus_rd("R4/R5/R7/R12 rand read", s, a);
        2: begin drive_pins(m_pins ^ ($urandom() & $urandom())); chk_outs("r6_rand"); end
        default: bus_rd("R6/R7 rand cause", 2'd1, 5'h00);
      endcase
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule